// File: doc/BRIEF.md
# UART Receive Byte Buffer

This block is the receive side of a memory-mapped serial port. A receiver front end hands it one byte per cycle, plus break, parity-error and frame-error pulses. Software reaches the block over a single-cycle register bus. A bus read returns its data in the same cycle. Any side effect of that read, such as a pop or a clear, takes place at the next clock edge.

The block has two modes. In queued mode, incoming bytes go into a ring buffer whose depth is a parameter. Reading the data register pops the oldest byte. In direct mode, one holding register keeps only the latest byte. Three outputs carry the receiver state: data-ready, the receive interrupt source and the error interrupt source. Masking of those sources happens outside this block.

Register words, selected by `bus_addr`: 0 control, 1 receive data, 2 queue status, 3 error status, 4 interrupt sources. Any other word reads as zero.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, data-ready and both interrupt sources are 0, queued mode is off, and the control, queue status and error status words all read 0.
- R2: In the control word, bit 0 selects queued mode and reads back. Writing 1 to bit 1 empties the receive queue. Bit 1 and bit 2 always read back 0, and bit 2 has no effect in this block.
- R3: In queued mode, stored bytes come out of word 1 in arrival order. Each read pops one byte, and the stored count never exceeds DEPTH.
- R4: In the queue status word, bits [7:0] hold the count, bit 8 is the full flag, and bit 9 is 1 whenever the error status is non-zero. While the queue is full, bits [7:0] read 0.
- R5: In queued mode, data-ready is 1 exactly while at least one byte is stored. It stays 1 after a pop that leaves bytes behind and drops when the last byte is popped.
- R6: In queued mode, reading word 1 while the queue is empty returns 0, sets the error source and leaves the count at 0.
- R7: A byte that arrives while the queue is full is dropped and the stored bytes are unchanged. The drop sets overrun (error status bit 0) and the error source, and data-ready stays 1.
- R8: A break event stores the byte 0x00, exactly as a received byte would, and sets error status bit 3. The parity and frame pulses set bits 1 and 2.
- R9: A read of the error status word returns the word and then clears it. A flag that is set in the same cycle as the read survives the clear.
- R10: In direct mode, each byte overwrites the holding register and sets data-ready. Reading word 1 returns the held byte and clears data-ready. If a read and a new byte arrive in the same cycle, the read wins and data-ready ends up 0.
- R11: The receive source (word 4, bit 0) is set by every stored byte in either mode. The error source is word 4, bit 1. Writing 1 to a bit of word 4 clears that source, but a set in the same cycle wins over the clear.
- R12: In queued mode, a pop and an accepted byte in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_push | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | The received byte |
| rx_break | input | 1 | Break event; stores 0x00 and takes precedence over rx_push |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_frame_err | input | 1 | Frame error pulse |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| data_ready | output | 1 | Received data is available |
| src_rx | output | 1 | Receive interrupt source |
| src_err | output | 1 | Error interrupt source |

## Verification
Read data depends only on state, so the bench compares it 1 ns after driving a read, within the same cycle. Every other effect of a cycle's inputs registers at the next rising edge. This covers pops, pushes, drops, clears and mode changes. Data-ready, both sources and later reads therefore show the result one edge after the stimulus. A behavioural queue model in the bench advances at that same edge, and the outputs are compared against it at the following falling edge of every cycle.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_DATA  = 3'd1,
    RA_FSTAT = 3'd2,
    RA_ESTAT = 3'd3,
    RA_SRC   = 3'd4
  } rxbuf_reg_e;

  // error status bit positions (software decodes these)
  localparam int ES_OVERRUN = 0;
  localparam int ES_PARITY  = 1;
  localparam int ES_FRAME   = 2;
  localparam int ES_BREAK   = 3;
  localparam int ES_W       = 4;

  // queue status word: count hidden while full
  function automatic logic [31:0] fstat_word(input logic [7:0] level,
                                             input logic is_full,
                                             input logic any_err);
    fstat_word = {22'd0, any_err, is_full, (is_full ? 8'd0 : level)};
  endfunction

endpackage

// File: rtl/rxbuf_ring.sv
module rxbuf_ring #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [7:0]       push_byte,
  input  logic             pop,
  output logic [7:0]       head_byte,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [7:0]       store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    wrap_inc = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (level == CNT_W'(DEPTH));
  assign empty     = (level == '0);
  assign head_byte = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      unique case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/rxbuf_errstat.sv
module rxbuf_errstat #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         rd_clr,
  output logic [W-1:0] value
);

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        value[i] <= 1'b0;
      else if (set[i])   value[i] <= 1'b1;
      else if (rd_clr)   value[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        rx_break,
  input  logic        rx_parity_err,
  input  logic        rx_frame_err,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        data_ready,
  output logic        src_rx,
  output logic        src_err
);
  import rxbuf_pkg::*;

  logic fifo_en, hold_rdy;
  logic [7:0] hold_byte;

  // bus decode
  logic rd_any, wr_ctrl, wr_src, rd_data_reg, rd_estat, rd_fstat;
  assign rd_any      = bus_sel & ~bus_wr;
  assign wr_ctrl     = bus_sel & bus_wr & (bus_addr == RA_CTRL);
  assign wr_src      = bus_sel & bus_wr & (bus_addr == RA_SRC);
  assign rd_data_reg = rd_any & (bus_addr == RA_DATA);
  assign rd_estat    = rd_any & (bus_addr == RA_ESTAT);
  assign rd_fstat    = rd_any & (bus_addr == RA_FSTAT);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[31:2];

  // ring status
  logic [7:0]       head_byte;
  logic [CNT_W-1:0] level;
  logic             full, empty;

  // named events
  logic       in_valid, flush, ev_pop, ev_empty_rd, ev_drop, ev_accept;
  logic       ev_accept_q, ev_hold_load;
  logic [7:0] in_byte;
  assign in_valid     = rx_push | rx_break;
  assign in_byte      = rx_break ? 8'h00 : rx_byte;
  assign flush        = wr_ctrl & bus_wdata[1];
  assign ev_pop       = fifo_en & rd_data_reg & ~empty;
  assign ev_empty_rd  = fifo_en & rd_data_reg & empty;
  assign ev_accept_q  = fifo_en & in_valid & ~full;
  assign ev_drop      = fifo_en & in_valid & full;
  assign ev_hold_load = ~fifo_en & in_valid;
  assign ev_accept    = ev_accept_q | ev_hold_load;

  rxbuf_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (ev_accept_q & ~flush),
    .push_byte (in_byte),
    .pop       (ev_pop & ~flush),
    .head_byte (head_byte),
    .level     (level),
    .full      (full),
    .empty     (empty)
  );

  logic [ES_W-1:0] err_set, err_bits;
  always_comb begin
    err_set             = '0;
    err_set[ES_OVERRUN] = ev_drop;
    err_set[ES_PARITY]  = rx_parity_err;
    err_set[ES_FRAME]   = rx_frame_err;
    err_set[ES_BREAK]   = rx_break;
  end

  rxbuf_errstat #(.W(ES_W)) u_errstat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (err_set),
    .rd_clr (rd_estat),
    .value  (err_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en   <= 1'b0;
      hold_byte <= 8'h00;
      hold_rdy  <= 1'b0;
      src_rx    <= 1'b0;
      src_err   <= 1'b0;
    end else begin
      if (wr_ctrl) fifo_en <= bus_wdata[0];
      if (ev_hold_load) hold_byte <= in_byte;
      if (~fifo_en & rd_data_reg) hold_rdy <= 1'b0;
      else if (ev_hold_load)      hold_rdy <= 1'b1;
      if (ev_accept)                  src_rx <= 1'b1;
      else if (wr_src & bus_wdata[0]) src_rx <= 1'b0;
      if (ev_drop | ev_empty_rd)      src_err <= 1'b1;
      else if (wr_src & bus_wdata[1]) src_err <= 1'b0;
    end
  end

  assign data_ready = fifo_en ? ~empty : hold_rdy;

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      unique case (bus_addr)
        RA_CTRL:  bus_rdata = {31'd0, fifo_en};
        RA_DATA:  bus_rdata = {24'd0, fifo_en ? (empty ? 8'h00 : head_byte) : hold_byte};
        RA_FSTAT: bus_rdata = fstat_word(8'(level), full, |err_bits);
        RA_ESTAT: bus_rdata = {{(32-ES_W){1'b0}}, err_bits};
        RA_SRC:   bus_rdata = {30'd0, src_err, src_rx};
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] level,
  input logic             full,
  input logic             fifo_en,
  input logic             data_ready,
  input logic             src_rx,
  input logic             src_err,
  input logic             ev_accept,
  input logic             ev_accept_q,
  input logic             ev_drop,
  input logic             ev_empty_rd,
  input logic             ev_pop,
  input logic             flush,
  input logic             wr_ctrl,
  input logic             rd_estat,
  input logic             rd_fstat,
  input logic             rd_data_reg,
  input logic [3:0]       err_set,
  input logic [3:0]       err_bits,
  input logic [31:0]      bus_rdata
);

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  a_r4_full_hides_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fstat && full) |-> (bus_rdata[8] && bus_rdata[7:0] == 8'd0));

  a_r5_ready_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept_q && !flush && !wr_ctrl) |=> data_ready);

  a_r6_empty_read_error: assert property (@(posedge clk) disable iff (!rst_n)
    ev_empty_rd |=> src_err);

  a_r7_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && !ev_pop && !flush) |=> (level == CNT_W'(DEPTH)));

  a_r9_read_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_estat && err_set == 4'd0) |=> (err_bits == 4'd0));

  a_r10_hold_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rd_data_reg && !wr_ctrl) |=> !data_ready);

  a_r11_store_sets_source: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> src_rx);

  a_r12_push_pop_balance: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && ev_accept_q && !flush) |=> $stable(level));

endmodule

bind uart_rx_buffer rxbuf_checker #(.DEPTH(DEPTH)) u_rxbuf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .level       (level),
  .full        (full),
  .fifo_en     (fifo_en),
  .data_ready  (data_ready),
  .src_rx      (src_rx),
  .src_err     (src_err),
  .ev_accept   (ev_accept),
  .ev_accept_q (ev_accept_q),
  .ev_drop     (ev_drop),
  .ev_empty_rd (ev_empty_rd),
  .ev_pop      (ev_pop),
  .flush       (flush),
  .wr_ctrl     (wr_ctrl),
  .rd_estat    (rd_estat),
  .rd_fstat    (rd_fstat),
  .rd_data_reg (rd_data_reg),
  .err_set     (err_set),
  .err_bits    (err_bits),
  .bus_rdata   (bus_rdata)
);

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_push = 1'b0, rx_break = 1'b0, rx_parity_err = 1'b0, rx_frame_err = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        data_ready, src_rx, src_err;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural model
  byte unsigned m_q[$];
  logic       m_fen = 1'b0, m_hrdy = 1'b0, m_rx = 1'b0, m_err = 1'b0;
  logic [7:0] m_hold = 8'h00;
  logic [3:0] m_est = 4'h0;

  always #4 clk = ~clk;

  uart_rx_buffer #(.DEPTH(DEPTH)) i_uart_rx_buffer (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_break(rx_break), .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .data_ready(data_ready), .src_rx(src_rx), .src_err(src_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] a);
    logic [31:0] v;
    v = 32'd0;
    case (a)
      3'd0: v = {31'd0, m_fen};
      3'd1: v = m_fen ? ((m_q.size() > 0) ? 32'(m_q[0]) : 32'd0) : 32'(m_hold);
      3'd2: begin
        v = (m_q.size() == DEPTH) ? 32'h100 : 32'(m_q.size());
        if (m_est != 4'h0) v = v | 32'h200;
      end
      3'd3: v = 32'(m_est);
      3'd4: v = {30'd0, m_err, m_rx};
      default: v = 32'd0;
    endcase
    return v;
  endfunction

  task automatic model_step();
    logic rd, wr, rdd, inb;
    logic [7:0] b;
    int sz;
    rd  = bus_sel && !bus_wr;
    wr  = bus_sel && bus_wr;
    rdd = rd && bus_addr == 3'd1;
    inb = rx_push || rx_break;
    b   = rx_break ? 8'h00 : rx_byte;
    if (wr && bus_addr == 3'd4) begin
      if (bus_wdata[0]) m_rx = 1'b0;
      if (bus_wdata[1]) m_err = 1'b0;
    end
    if (rd && bus_addr == 3'd3) m_est = 4'h0;
    if (m_fen) begin
      sz = m_q.size();
      if (rdd) begin
        if (sz > 0) void'(m_q.pop_front());
        else m_err = 1'b1;
      end
      if (inb) begin
        if (sz < DEPTH) begin m_q.push_back(b); m_rx = 1'b1; end
        else begin m_est[0] = 1'b1; m_err = 1'b1; end
      end
    end else begin
      if (inb) begin m_hold = b; m_hrdy = 1'b1; m_rx = 1'b1; end
      if (rdd) m_hrdy = 1'b0;
    end
    if (rx_parity_err) m_est[1] = 1'b1;
    if (rx_frame_err)  m_est[2] = 1'b1;
    if (rx_break)      m_est[3] = 1'b1;
    if (wr && bus_addr == 3'd0) begin
      if (bus_wdata[1]) m_q.delete();
      m_fen = bus_wdata[0];
    end
  endtask

  // one cycle: inputs already driven at the falling edge
  task automatic tick(input string tag, input logic chk, input logic [31:0] lit);
    #1;
    if (bus_sel && !bus_wr) begin
      check(tag_for(bus_addr), bus_rdata, model_read(bus_addr));
      if (chk) check(tag, bus_rdata, lit);
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(m_fen ? "R5" : "R10", {31'd0, data_ready},
          {31'd0, m_fen ? (m_q.size() != 0) : m_hrdy});
    check("R11", {31'd0, src_rx}, {31'd0, m_rx});
    check("R11", {31'd0, src_err}, {31'd0, m_err});
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0;
    rx_push = 1'b0; rx_break = 1'b0; rx_parity_err = 1'b0; rx_frame_err = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    tick(tag, 1'b1, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick("", 1'b0, 32'd0);
  endtask

  task automatic push(input logic [7:0] b);
    rx_push = 1'b1; rx_byte = b;
    tick("", 1'b0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {29'd0, data_ready, src_rx, src_err}, 32'd0);
    rd(3'd0, 32'd0, "R1");
    rd(3'd2, 32'd0, "R1");
    rd(3'd3, 32'd0, "R1");

    // R10 direct mode
    push(8'h41);
    rd(3'd1, 32'h41, "R10");
    check("R10", {31'd0, data_ready}, 32'd0);
    push(8'h42); push(8'h43);
    rd(3'd1, 32'h43, "R10");
    push(8'h44);
    rx_push = 1'b1; rx_byte = 8'h45; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd1;
    tick("R10", 1'b1, 32'h44);
    check("R10", {31'd0, data_ready}, 32'd0);
    rd(3'd4, 32'd1, "R11");
    wr(3'd4, 32'd1);
    rd(3'd4, 32'd0, "R11");

    // R2 control
    wr(3'd0, 32'd1);
    rd(3'd0, 32'd1, "R2");
    wr(3'd0, 32'd7);
    rd(3'd0, 32'd1, "R2");

    // R3 / R4 / R5 order and count
    push(8'h10); push(8'h11); push(8'h12);
    rd(3'd2, 32'd3, "R4");
    rd(3'd1, 32'h10, "R3");
    check("R5", {31'd0, data_ready}, 32'd1);
    rd(3'd1, 32'h11, "R3");
    rd(3'd1, 32'h12, "R3");
    check("R5", {31'd0, data_ready}, 32'd0);

    // R6 empty read
    rd(3'd1, 32'd0, "R6");
    rd(3'd4, 32'd3, "R6");
    rd(3'd2, 32'd0, "R6");
    wr(3'd4, 32'd3);

    // R4 / R7 full and overflow
    for (int i = 0; i < DEPTH; i++) push(8'(8'h20 + i));
    rd(3'd2, 32'h100, "R4");
    push(8'hEE);
    rd(3'd2, 32'h300, "R7");
    rd(3'd3, 32'd1, "R7");
    check("R7", {31'd0, data_ready}, 32'd1);
    rd(3'd1, 32'h20, "R7");

    // R12 simultaneous push and pop
    rx_push = 1'b1; rx_byte = 8'h77; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd1;
    tick("R12", 1'b1, 32'h21);
    rd(3'd2, 32'd15, "R12");
    for (int i = 2; i < DEPTH; i++) rd(3'd1, 32'(8'h20 + i), "R3");
    rd(3'd1, 32'h77, "R3");

    // R8 break and line errors
    push(8'h55);
    rx_break = 1'b1;
    tick("", 1'b0, 32'd0);
    rd(3'd1, 32'h55, "R8");
    rd(3'd2, 32'h201, "R8");
    rd(3'd1, 32'h00, "R8");
    rd(3'd3, 32'h8, "R8");
    rx_parity_err = 1'b1; rx_frame_err = 1'b1;
    tick("", 1'b0, 32'd0);
    rd(3'd3, 32'h6, "R8");

    // R9 set during clearing read
    rx_parity_err = 1'b1;
    tick("", 1'b0, 32'd0);
    rx_frame_err = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd3;
    tick("R9", 1'b1, 32'h2);
    rd(3'd3, 32'h4, "R9");
    rd(3'd3, 32'h0, "R9");

    // R11 set beats same-cycle clear
    wr(3'd4, 32'd3);
    rx_push = 1'b1; rx_byte = 8'h60; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'd3;
    tick("", 1'b0, 32'd0);
    rd(3'd4, 32'd1, "R11");

    // R2 flush with data
    push(8'h61);
    wr(3'd0, 32'd3);
    rd(3'd2, 32'd0, "R2");
    check("R2", {31'd0, data_ready}, 32'd0);
    wr(3'd0, 32'd0);
    rd(3'd0, 32'd0, "R2");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule